// File: doc/BRIEF.md
# Memory Bus Bandwidth Profiler

This block watches the transaction stream between the requesters of a shared DRAM controller and the controller itself. It gathers traffic statistics for one chosen requester over a measurement window whose length is given in clock cycles. The bus protocol is reduced to per-cycle signals: a controller-busy flag, a read strobe, a write strobe, a byte count and a requester ID.

During each window six saturating counters accumulate: elapsed cycles, controller-busy cycles, read and write accesses, and read and write bytes. When the window closes, all six values are copied into result registers and the live counters restart from zero in the same cycle. A shared serial divider then works out five derived figures:

- mean read burst size
- mean write burst size
- mean bytes per access
- bus load percentage
- data utilization percentage, measured against a double-data-rate 64-bit data path that moves 16 bytes per busy cycle

When all five figures are ready, a one-cycle flag announces them.

A run holds a programmed number of back-to-back windows. An all-ones count makes the run endless until a stop request arrives.

Top module: `bus_bw_profiler`

## Requirements
- R1: After reset, `running` and `res_valid` are low and every result output is zero.
- R2: `res_total` equals the programmed window length, and a length of 0 acts as 1. The window covers the N rising edges that follow the edge that samples `ctl_start`.
- R3: `res_busy` counts the cycles in the window with `mon_busy` high, whatever the value of `mon_id`.
- R4: Read and write accesses and bytes are counted only when `mon_id` equals the master latched at start. Traffic from any other ID leaves those four results unchanged.
- R5: Every counter stops at its all-ones value instead of wrapping.
- R6: `res_avg_rd` is read bytes / read accesses and `res_avg_wr` is write bytes / write accesses, using integer floor. Each is 0 when its divisor is 0.
- R7: `res_avg_acc` is (read bytes + write bytes) / (read accesses + write accesses), and 0 when there are no accesses.
- R8: `res_load_pct` is busy × 100 / total, using integer floor, so it never exceeds 100.
- R9: `res_util_pct` is (read bytes + write bytes) × 100 / (busy × 16), and 0 when busy is 0.
- R10: When a window closes, the counts of the next window begin at zero, with no carry-over from the previous window.
- R11: `ctl_loops` = N (0 acts as 1) runs N windows and then `running` falls. An all-ones `ctl_loops` keeps running until `ctl_stop`.
- R12: `res_valid` is a one-cycle pulse that marks updated derived results, once per completed window.
- R13: `ctl_stop` during a run drops `running` on the next cycle and discards the partial window. No result changes and no `res_valid` follows for that window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_start | input | 1 | Start pulse; accepted only while idle |
| ctl_stop | input | 1 | Abort the current run |
| ctl_window_len | input | CNT_W | Window length in cycles |
| ctl_loops | input | LOOP_W | Number of windows; all-ones means endless |
| ctl_master | input | ID_W | Requester ID to profile |
| mon_busy | input | 1 | Controller busy this cycle |
| mon_rd | input | 1 | Read access this cycle |
| mon_wr | input | 1 | Write access this cycle |
| mon_bytes | input | BYTE_W | Bytes moved by this access |
| mon_id | input | ID_W | Requester ID of this access |
| running | output | 1 | A run is in progress |
| res_valid | output | 1 | Derived results updated (one-cycle pulse) |
| res_total | output | CNT_W | Cycles in the last window |
| res_busy | output | CNT_W | Busy cycles in the last window |
| res_rd_acc | output | CNT_W | Read accesses |
| res_wr_acc | output | CNT_W | Write accesses |
| res_rd_bytes | output | CNT_W | Read bytes |
| res_wr_bytes | output | CNT_W | Write bytes |
| res_avg_rd | output | CNT_W | Mean read burst size |
| res_avg_wr | output | CNT_W | Mean write burst size |
| res_avg_acc | output | CNT_W | Mean bytes per access |
| res_load_pct | output | CNT_W | Bus load percentage |
| res_util_pct | output | CNT_W | Data utilization percentage |

## Verification
The assertions assume a single transaction per cycle, so `mon_rd` and `mon_wr` are never high together. Each stimulus pattern issues at most one strobe per cycle, alternating reads, writes and foreign-ID traffic across separate cycles. The divider sequence needs about five times the divider width in cycles, and the checks on derived results assume that windows are at least that long. The multi-window and endless runs therefore use windows of 150 to 200 cycles. The shortest windows are used only in single-window runs, where the bench waits for `res_valid` before it starts anything new.

// File: rtl/prof_pkg.sv
package prof_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } win_state_e;

    typedef enum logic [2:0] {
        Q_AVG_RD  = 3'd0,
        Q_AVG_WR  = 3'd1,
        Q_AVG_ACC = 3'd2,
        Q_LOAD    = 3'd3,
        Q_UTIL    = 3'd4
    } quot_sel_e;

    // counter slots
    localparam int IX_TOT  = 0;
    localparam int IX_BUSY = 1;
    localparam int IX_RDA  = 2;
    localparam int IX_WRA  = 3;
    localparam int IX_RDB  = 4;
    localparam int IX_WRB  = 5;
    localparam int NUM_CNT = 6;
    localparam int NUM_QUOT = 5;

    // 64-bit data path, two transfers per clock
    localparam int DDR_BYTES_PER_CYC = 16;
    localparam int PCT_SCALE = 100;

endpackage

// File: rtl/prof_sat_counter.sv
module prof_sat_counter #(
    parameter int W     = 32,
    parameter int INC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc_en,
    input  logic [INC_W-1:0] inc_val,
    output logic [W-1:0]     nxt
);
    localparam int PAD = W + 1 - INC_W;

    logic [W-1:0] cnt_d, cnt_q;
    logic [W:0]   sum_w;

    always_comb begin
        sum_w = {1'b0, cnt_q} + {{PAD{1'b0}}, inc_val};
        if (inc_en) begin
            nxt = sum_w[W] ? {W{1'b1}} : sum_w[W-1:0];
        end else begin
            nxt = cnt_q;
        end
        cnt_d = clr ? '0 : nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    p_sat_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == {W{1'b1}} && !clr) |=> (cnt_q == {W{1'b1}}));

    p_clr_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0));

endmodule

// File: rtl/prof_divider.sv
module prof_divider #(
    parameter int W = 40
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] num,
    input  logic [W-1:0] den,
    output logic         done,
    output logic [W-1:0] quo
);
    localparam int CW = $clog2(W + 1);

    typedef struct packed {
        logic          active;
        logic          done;
        logic [CW-1:0] step;
        logic [W-1:0]  rem;
        logic [W-1:0]  quo;
        logic [W-1:0]  den;
    } div_state_t;

    div_state_t q, d;
    logic [W:0] r_sh;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        r_sh   = {q.rem, q.quo[W-1]};
        if (start) begin
            d.active = (den != '0);
            d.done   = (den == '0);
            d.step   = '0;
            d.rem    = '0;
            d.quo    = (den == '0) ? '0 : num;
            d.den    = den;
        end else if (q.active) begin
            if (r_sh >= {1'b0, q.den}) begin
                d.rem = W'(r_sh - {1'b0, q.den});
                d.quo = {q.quo[W-2:0], 1'b1};
            end else begin
                d.rem = r_sh[W-1:0];
                d.quo = {q.quo[W-2:0], 1'b0};
            end
            d.step = q.step + CW'(1);
            if (q.step == CW'(W - 1)) begin
                d.active = 1'b0;
                d.done   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign done = q.done;
    assign quo  = q.quo;

    p_zero_den_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (start && den == '0) |=> (done && quo == '0));

endmodule

// File: rtl/bus_bw_profiler.sv
module bus_bw_profiler
    import prof_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int BYTE_W = 8,
    parameter int ID_W   = 4,
    parameter int LOOP_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_start,
    input  logic              ctl_stop,
    input  logic [CNT_W-1:0]  ctl_window_len,
    input  logic [LOOP_W-1:0] ctl_loops,
    input  logic [ID_W-1:0]   ctl_master,
    input  logic              mon_busy,
    input  logic              mon_rd,
    input  logic              mon_wr,
    input  logic [BYTE_W-1:0] mon_bytes,
    input  logic [ID_W-1:0]   mon_id,
    output logic              running,
    output logic              res_valid,
    output logic [CNT_W-1:0]  res_total,
    output logic [CNT_W-1:0]  res_busy,
    output logic [CNT_W-1:0]  res_rd_acc,
    output logic [CNT_W-1:0]  res_wr_acc,
    output logic [CNT_W-1:0]  res_rd_bytes,
    output logic [CNT_W-1:0]  res_wr_bytes,
    output logic [CNT_W-1:0]  res_avg_rd,
    output logic [CNT_W-1:0]  res_avg_wr,
    output logic [CNT_W-1:0]  res_avg_acc,
    output logic [CNT_W-1:0]  res_load_pct,
    output logic [CNT_W-1:0]  res_util_pct
);
    localparam int DIV_W = CNT_W + 8;

    typedef struct packed {
        win_state_e                     st;
        logic [CNT_W-1:0]               win_len;
        logic [CNT_W-1:0]               win_cnt;
        logic [LOOP_W-1:0]              loops_left;
        logic                           loop_inf;
        logic [ID_W-1:0]                master;
        logic [NUM_CNT-1:0][CNT_W-1:0]  snap;
        logic [NUM_QUOT-1:0][CNT_W-1:0] quot;
        logic                           seq_act;
        quot_sel_e                      seq_idx;
        logic                           go;
        logic                           valid;
    } prof_state_t;

    prof_state_t q, d;

    logic                            run, hit, win_end, cnt_clr;
    logic [NUM_CNT-1:0]              inc_en;
    logic [NUM_CNT-1:0][BYTE_W-1:0]  inc_val;
    logic [NUM_CNT-1:0][CNT_W-1:0]   cnt_nxt;
    logic [DIV_W-1:0]                op_num, op_den, byte_sum, acc_sum;
    logic [DIV_W-1:0]                div_quo;
    logic                            div_done;
    logic [CNT_W-1:0]                quo_sat;

    // ---------------- counter feed ----------------
    always_comb begin
        run     = (q.st == ST_RUN);
        hit     = (mon_id == q.master);
        win_end = run && (q.win_cnt == q.win_len - CNT_W'(1));
        cnt_clr = !run || ctl_stop || win_end;

        inc_en[IX_TOT]   = run;
        inc_val[IX_TOT]  = BYTE_W'(1);
        inc_en[IX_BUSY]  = run && mon_busy;
        inc_val[IX_BUSY] = BYTE_W'(1);
        inc_en[IX_RDA]   = run && mon_rd && hit;
        inc_val[IX_RDA]  = BYTE_W'(1);
        inc_en[IX_WRA]   = run && mon_wr && hit;
        inc_val[IX_WRA]  = BYTE_W'(1);
        inc_en[IX_RDB]   = run && mon_rd && hit;
        inc_val[IX_RDB]  = mon_bytes;
        inc_en[IX_WRB]   = run && mon_wr && hit;
        inc_val[IX_WRB]  = mon_bytes;
    end

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        prof_sat_counter #(
            .W     (CNT_W),
            .INC_W (BYTE_W)
        ) i_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (cnt_clr),
            .inc_en  (inc_en[g]),
            .inc_val (inc_val[g]),
            .nxt     (cnt_nxt[g])
        );
    end

    // ---------------- divider operand select ----------------
    always_comb begin
        byte_sum = DIV_W'(q.snap[IX_RDB]) + DIV_W'(q.snap[IX_WRB]);
        acc_sum  = DIV_W'(q.snap[IX_RDA]) + DIV_W'(q.snap[IX_WRA]);
        case (q.seq_idx)
            Q_AVG_RD: begin
                op_num = DIV_W'(q.snap[IX_RDB]);
                op_den = DIV_W'(q.snap[IX_RDA]);
            end
            Q_AVG_WR: begin
                op_num = DIV_W'(q.snap[IX_WRB]);
                op_den = DIV_W'(q.snap[IX_WRA]);
            end
            Q_AVG_ACC: begin
                op_num = byte_sum;
                op_den = acc_sum;
            end
            Q_LOAD: begin
                op_num = DIV_W'(q.snap[IX_BUSY]) * DIV_W'(PCT_SCALE);
                op_den = DIV_W'(q.snap[IX_TOT]);
            end
            default: begin
                op_num = byte_sum * DIV_W'(PCT_SCALE);
                op_den = DIV_W'(q.snap[IX_BUSY]) * DIV_W'(DDR_BYTES_PER_CYC);
            end
        endcase
        quo_sat = (|div_quo[DIV_W-1:CNT_W]) ? {CNT_W{1'b1}} : div_quo[CNT_W-1:0];
    end

    prof_divider #(
        .W (DIV_W)
    ) i_div (
        .clk   (clk),
        .rst_n (rst_n),
        .start (q.go),
        .num   (op_num),
        .den   (op_den),
        .done  (div_done),
        .quo   (div_quo)
    );

    // ---------------- next state ----------------
    always_comb begin
        d       = q;
        d.go    = 1'b0;
        d.valid = 1'b0;

        if (q.seq_act && div_done) begin
            case (q.seq_idx)
                Q_AVG_RD:  d.quot[0] = quo_sat;
                Q_AVG_WR:  d.quot[1] = quo_sat;
                Q_AVG_ACC: d.quot[2] = quo_sat;
                Q_LOAD:    d.quot[3] = quo_sat;
                default:   d.quot[4] = quo_sat;
            endcase
            if (q.seq_idx == Q_UTIL) begin
                d.seq_act = 1'b0;
                d.valid   = 1'b1;
            end else begin
                d.seq_idx = quot_sel_e'(q.seq_idx + 3'd1);
                d.go      = 1'b1;
            end
        end

        case (q.st)
            ST_IDLE: begin
                if (ctl_start) begin
                    d.st         = ST_RUN;
                    d.win_len    = (ctl_window_len == '0) ? CNT_W'(1) : ctl_window_len;
                    d.win_cnt    = '0;
                    d.loops_left = (ctl_loops == '0) ? LOOP_W'(1) : ctl_loops;
                    d.loop_inf   = &ctl_loops;
                    d.master     = ctl_master;
                end
            end
            ST_RUN: begin
                if (ctl_stop) begin
                    d.st = ST_IDLE;
                end else if (win_end) begin
                    d.win_cnt = '0;
                    d.snap    = cnt_nxt;
                    d.seq_act = 1'b1;
                    d.seq_idx = Q_AVG_RD;
                    d.go      = 1'b1;
                    d.valid   = 1'b0;
                    if (!q.loop_inf) begin
                        if (q.loops_left == LOOP_W'(1)) d.st = ST_IDLE;
                        else d.loops_left = q.loops_left - LOOP_W'(1);
                    end
                end else begin
                    d.win_cnt = q.win_cnt + CNT_W'(1);
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign running      = (q.st == ST_RUN);
    assign res_valid    = q.valid;
    assign res_total    = q.snap[IX_TOT];
    assign res_busy     = q.snap[IX_BUSY];
    assign res_rd_acc   = q.snap[IX_RDA];
    assign res_wr_acc   = q.snap[IX_WRA];
    assign res_rd_bytes = q.snap[IX_RDB];
    assign res_wr_bytes = q.snap[IX_WRB];
    assign res_avg_rd   = q.quot[0];
    assign res_avg_wr   = q.quot[1];
    assign res_avg_acc  = q.quot[2];
    assign res_load_pct = q.quot[3];
    assign res_util_pct = q.quot[4];

    // ---------------- assertions ----------------
    p_one_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(mon_rd && mon_wr));

    p_win_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (q.win_cnt < q.win_len));

    p_stop_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (running && ctl_stop) |=> !running);

    p_valid_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    p_load_max_r8: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_load_pct <= CNT_W'(PCT_SCALE)));

endmodule

// File: tb/test_bus_bw_profiler.sv
module test_bus_bw_profiler;
    localparam int CW = 16;
    localparam int BW = 8;
    localparam int IW = 4;
    localparam int LW = 16;
    localparam longint MAXV = 65535;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic          ctl_start = 0, ctl_stop = 0;
    logic [CW-1:0] ctl_window_len = '0;
    logic [LW-1:0] ctl_loops = '0;
    logic [IW-1:0] ctl_master = '0;
    logic          mon_busy = 0, mon_rd = 0, mon_wr = 0;
    logic [BW-1:0] mon_bytes = '0;
    logic [IW-1:0] mon_id = '0;
    logic          running, res_valid;
    logic [CW-1:0] res_total, res_busy, res_rd_acc, res_wr_acc, res_rd_bytes, res_wr_bytes;
    logic [CW-1:0] res_avg_rd, res_avg_wr, res_avg_acc, res_load_pct, res_util_pct;

    bus_bw_profiler #(.CNT_W(CW), .BYTE_W(BW), .ID_W(IW), .LOOP_W(LW)) i_bus_bw_profiler (
        .clk(clk), .rst_n(rst_n), .ctl_start(ctl_start), .ctl_stop(ctl_stop),
        .ctl_window_len(ctl_window_len), .ctl_loops(ctl_loops), .ctl_master(ctl_master),
        .mon_busy(mon_busy), .mon_rd(mon_rd), .mon_wr(mon_wr), .mon_bytes(mon_bytes),
        .mon_id(mon_id), .running(running), .res_valid(res_valid),
        .res_total(res_total), .res_busy(res_busy), .res_rd_acc(res_rd_acc),
        .res_wr_acc(res_wr_acc), .res_rd_bytes(res_rd_bytes), .res_wr_bytes(res_wr_bytes),
        .res_avg_rd(res_avg_rd), .res_avg_wr(res_avg_wr), .res_avg_acc(res_avg_acc),
        .res_load_pct(res_load_pct), .res_util_pct(res_util_pct));

    int n_chk = 0, n_fail = 0;
    longint e_tot, e_busy, e_rda, e_wra, e_rdb, e_wrb;
    longint s_tot, s_busy, s_rda, s_wra, s_rdb, s_wrb;
    bit watch_mid = 0, got_mid = 0;
    int pulses = 0;

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic longint sat(input longint v);
        return (v > MAXV) ? MAXV : v;
    endfunction

    function automatic longint qdiv(input longint n, input longint d);
        if (d == 0) return 0;
        return sat(n / d);
    endfunction

    task automatic clear_model();
        e_tot = 0; e_busy = 0; e_rda = 0; e_wra = 0; e_rdb = 0; e_wrb = 0;
    endtask

    task automatic save_exp();
        s_tot = e_tot; s_busy = e_busy; s_rda = e_rda; s_wra = e_wra; s_rdb = e_rdb; s_wrb = e_wrb;
    endtask

    task automatic idle_inputs();
        mon_busy = 0; mon_rd = 0; mon_wr = 0; mon_bytes = '0; mon_id = '0;
    endtask

    // one cycle of stimulus plus the reference count update
    task automatic drive(input int kind, input int i, input logic [IW-1:0] m);
        idle_inputs();
        mon_id = m;
        case (kind)
            1: begin mon_busy = 1; mon_rd = 1; mon_bytes = 8'd16; end
            2: begin
                mon_busy = ((i % 4) != 3);
                case (i % 3)
                    0: begin mon_rd = 1; mon_bytes = BW'(8 + (i % 5) * 8); end
                    1: begin mon_wr = 1; mon_bytes = 8'd64; end
                    default: begin mon_rd = 1; mon_bytes = 8'd16; mon_id = m ^ 4'd1; end
                endcase
            end
            3: begin mon_busy = 1; mon_wr = 1; mon_bytes = 8'd40; mon_id = m ^ 4'd1; end
            4: begin mon_busy = 1; mon_rd = 1; mon_bytes = 8'd255; end
            default: ;
        endcase
        e_tot = sat(e_tot + 1);
        if (mon_busy) e_busy = sat(e_busy + 1);
        if (mon_rd && mon_id == m) begin e_rda = sat(e_rda + 1); e_rdb = sat(e_rdb + mon_bytes); end
        if (mon_wr && mon_id == m) begin e_wra = sat(e_wra + 1); e_wrb = sat(e_wrb + mon_bytes); end
    endtask

    task automatic start_run(input int len, input logic [LW-1:0] loops, input logic [IW-1:0] m);
        @(negedge clk);
        ctl_window_len = CW'(len); ctl_loops = loops; ctl_master = m; ctl_start = 1;
    endtask

    task automatic feed(input int len, input int kind, input logic [IW-1:0] m);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            ctl_start = 0;
            if (res_valid) begin
                pulses++;
                if (watch_mid) begin
                    check_saved("R10");
                    watch_mid = 0;
                    got_mid = 1;
                end
            end
            drive(kind, i, m);
        end
    endtask

    task automatic wait_valid(input string req);
        bit found = 0;
        for (int k = 0; k < 1500 && !found; k++) begin
            @(negedge clk);
            if (res_valid) found = 1;
        end
        chk(req, "res_valid arrives", found, 1);
        @(negedge clk);
        chk("R12", "res_valid one cycle wide", res_valid, 0);
    endtask

    task automatic check_saved(input string tag);
        chk({tag, " R2"}, "total", res_total, s_tot);
        chk({tag, " R3"}, "busy", res_busy, s_busy);
        chk({tag, " R4"}, "rd_acc", res_rd_acc, s_rda);
        chk({tag, " R4"}, "wr_acc", res_wr_acc, s_wra);
        chk({tag, " R4"}, "rd_bytes", res_rd_bytes, s_rdb);
        chk({tag, " R4"}, "wr_bytes", res_wr_bytes, s_wrb);
        chk({tag, " R6"}, "avg_rd", res_avg_rd, qdiv(s_rdb, s_rda));
        chk({tag, " R6"}, "avg_wr", res_avg_wr, qdiv(s_wrb, s_wra));
        chk({tag, " R7"}, "avg_acc", res_avg_acc, qdiv(s_rdb + s_wrb, s_rda + s_wra));
        chk({tag, " R8"}, "load_pct", res_load_pct, qdiv(s_busy * 100, s_tot));
        chk({tag, " R9"}, "util_pct", res_util_pct, qdiv((s_rdb + s_wrb) * 100, s_busy * 16));
    endtask

    task automatic run_single(input string tag, input int len, input int kind, input logic [IW-1:0] m);
        int eff;
        eff = (len == 0) ? 1 : len;
        clear_model();
        start_run(len, 16'd1, m);
        feed(eff, kind, m);
        @(negedge clk);
        idle_inputs();
        save_exp();
        wait_valid(tag);
        check_saved(tag);
        chk({tag, " R11"}, "running after single window", running, 0);
    endtask

    task automatic t_reset();
        chk("R1", "running", running, 0);
        chk("R1", "res_valid", res_valid, 0);
        chk("R1", "res_total", res_total, 0);
        chk("R1", "res_rd_bytes", res_rd_bytes, 0);
        chk("R1", "res_util_pct", res_util_pct, 0);
    endtask

    task automatic t_two_windows();
        clear_model();
        start_run(200, 16'd2, 4'd5);
        feed(200, 2, 4'd5);
        save_exp();
        clear_model();
        watch_mid = 1; got_mid = 0;
        feed(200, 1, 4'd5);
        @(negedge clk);
        idle_inputs();
        chk("R10", "first window result seen", got_mid, 1);
        save_exp();
        wait_valid("R10");
        check_saved("R10");
        chk("R11", "running after two windows", running, 0);
    endtask

    task automatic t_forever();
        pulses = 0;
        clear_model();
        start_run(150, 16'hFFFF, 4'd2);
        feed(700, 1, 4'd2);
        chk("R11", "still running when endless", running, 1);
        chk("R11", "at least three windows reported", (pulses >= 3), 1);
        ctl_stop = 1;
        @(negedge clk);
        ctl_stop = 0;
        idle_inputs();
        chk("R13", "running after stop", running, 0);
    endtask

    task automatic t_abort();
        longint old_total;
        bit seen = 0;
        repeat (300) @(negedge clk);
        old_total = res_total;
        clear_model();
        start_run(100, 16'd1, 4'd3);
        feed(40, 2, 4'd3);
        ctl_stop = 1;
        @(negedge clk);
        ctl_stop = 0;
        idle_inputs();
        chk("R13", "running after abort", running, 0);
        for (int k = 0; k < 400; k++) begin
            @(negedge clk);
            if (res_valid) seen = 1;
        end
        chk("R13", "no res_valid for aborted window", seen, 0);
        chk("R13", "total unchanged", res_total, old_total);
    endtask

    initial begin
        #(200000 * 20);
        n_fail++;
        $display("FAIL watchdog expired: run did not finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        run_single("reads", 40, 1, 4'd7);
        run_single("mixed", 60, 2, 4'd3);
        run_single("foreign", 30, 3, 4'd9);
        run_single("zero_len", 0, 1, 4'd1);
        run_single("idle", 10, 0, 4'd1);
        run_single("R5 saturate", 300, 4, 4'd6);
        chk("R5", "rd_bytes pinned at max", res_rd_bytes, MAXV);
        t_two_windows();
        t_forever();
        t_abort();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule